// File: doc/BRIEF.md
# Sticky Status Register Bank

This block holds a bank of event flag registers. Logic elsewhere on the chip raises one-cycle pulses on an event vector. Each pulse sets its flag, and the flag stays set until software clears it. Software reaches the bank through a small register port with an address, separate read and write strobes, write data and registered read data. The same port also holds one mask register per flag register and a control register.

A single bit in the control register selects how every flag in the bank is cleared. In write-clear mode, a write clears exactly the flags whose write-data bit is one. Several software tasks that do not coordinate can therefore each read the register and then clear only the flags they own. In read-clear mode, a read returns the flags as they stood and clears them in the same access. Each access acts once per strobe assertion, however long the strobe is held.

The interrupt output is one registered bit. It is high when any set flag has its mask bit set.

Top module: `sticky_status_bank`

## Requirements
- R1: After reset, every flag register, every mask register and the control register read 0, and the interrupt output is 0. A control value of 0 means write-clear mode.
- R2: An event pulse on bit `k*REG_W+b` of `evt_in` sets bit `b` of flag register `k`. In write-clear mode, the bit stays set across any number of reads.
- R3: In write-clear mode (control bit 0 = 0), a write to a flag register clears the bits written as 1 and leaves the bits written as 0 unchanged.
- R4: In read-clear mode (control bit 0 = 1), a read of a flag register returns its value from before the access, and every bit that was set is cleared by that access.
- R5: Each strobe assertion is one access. A read strobe held for several cycles clears only once, so an event arriving while the strobe is still high stays set.
- R6: In read-clear mode, writes to flag registers leave their contents unchanged.
- R7: When an event pulse and a clear hit the same bit in the same clock cycle, the bit ends up set. This holds in both modes.
- R8: The interrupt output equals the OR over all bits of (flag AND mask). It changes one clock cycle after the flag or mask bits that cause the change.
- R9: Read data appears on `reg_rdata` one clock cycle after the rising edge of `reg_rd` is sampled, and it holds that value until the next read access.
- R10: Address map: flag register `k` is at address `k`, mask register `k` is at `NUM_REGS+k`, and the control register is at `2*NUM_REGS` (mode in bit 0). Any other address reads 0, and writes to it change nothing. Reads of mask and control registers clear nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | ADDR_W | Register address |
| reg_rd | input | 1 | Read strobe; one access per assertion |
| reg_wr | input | 1 | Write strobe; one access per assertion |
| reg_wdata | input | REG_W | Write data |
| reg_rdata | output | REG_W | Registered read data |
| evt_in | input | NUM_REGS*REG_W | One-cycle event pulses, REG_W bits per flag register |
| irq | output | 1 | Registered OR of masked flags |

## Verification
An event pulse and a clear can land on the same flag in the same cycle. The clear may come from a read in read-clear mode or from a one-bit write in write-clear mode. The bench provokes this by raising the event bit in the same cycle as the strobe's first sampled edge. It judges the result by a later read, which must show the bit still set, while the colliding read itself returns the value from before the access. A second overlap is an event arriving while a read strobe is held high. A follow-up read must find that event set, because the held strobe counted as only one access.

// File: rtl/stsb_pkg.sv
package stsb_pkg;

    typedef enum logic {
        CLR_BY_WRITE = 1'b0,
        CLR_BY_READ  = 1'b1
    } clr_mode_e;

    typedef struct packed {
        logic rd_seen;
        logic wr_seen;
    } strobe_hist_t;

    localparam int unsigned MODE_BIT = 0;

endpackage

// File: rtl/stsb_strobe_edge.sv
module stsb_strobe_edge
    import stsb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic rd_i,
    input  logic wr_i,
    output logic rd_pulse_o,
    output logic wr_pulse_o
);

    strobe_hist_t hist_d, hist_q;

    always_comb begin
        hist_d         = hist_q;
        hist_d.rd_seen = rd_i;
        hist_d.wr_seen = wr_i;
        rd_pulse_o     = rd_i & ~hist_q.rd_seen;
        wr_pulse_o     = wr_i & ~hist_q.wr_seen;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) hist_q <= '0;
        else        hist_q <= hist_d;
    end

    // R5
    rd_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_pulse_o |=> !rd_pulse_o);

    // R5
    wr_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_pulse_o |=> !wr_pulse_o);

endmodule

// File: rtl/stsb_sticky_reg.sv
module stsb_sticky_reg
    import stsb_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  clr_mode_e    mode_i,
    input  logic         rd_hit_i,
    input  logic         wr_hit_i,
    input  logic [W-1:0] wdata_i,
    input  logic [W-1:0] evt_i,
    output logic [W-1:0] stat_o
);

    typedef struct packed {
        logic [W-1:0] stat;
    } flag_state_t;

    flag_state_t st_d, st_q;
    logic [W-1:0] clr_mask;

    always_comb begin
        st_d     = st_q;
        clr_mask = '0;
        if (mode_i == CLR_BY_READ && rd_hit_i) begin
            clr_mask = st_q.stat;
        end else if (mode_i == CLR_BY_WRITE && wr_hit_i) begin
            clr_mask = wdata_i;
        end
        // set wins over clear
        st_d.stat = (st_q.stat & ~clr_mask) | evt_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign stat_o = st_q.stat;

    // R7
    evt_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_i != '0) |=> ((stat_o & $past(evt_i)) == $past(evt_i)));

    // R3
    w1c_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == CLR_BY_WRITE && wr_hit_i) |=>
        ((stat_o & ~$past(wdata_i)) == (($past(stat_o) | $past(evt_i)) & ~$past(wdata_i))));

    // R4
    cor_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == CLR_BY_READ && rd_hit_i) |=> (stat_o == $past(evt_i)));

    // R6
    cor_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == CLR_BY_READ && !rd_hit_i) |=>
        ((stat_o & $past(stat_o)) == $past(stat_o)));

endmodule

// File: rtl/stsb_irq_or.sv
module stsb_irq_or #(
    parameter int unsigned N = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] stat_i,
    input  logic [N-1:0] mask_i,
    output logic         irq_o
);

    typedef struct packed {
        logic irq;
    } irq_state_t;

    irq_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.irq = |(stat_i & mask_i);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq_o = st_q.irq;

    // R8
    irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((stat_i & mask_i) != '0) |=> irq_o);

    // R8
    irq_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((stat_i & mask_i) == '0) |=> !irq_o);

endmodule

// File: rtl/sticky_status_bank.sv
module sticky_status_bank
    import stsb_pkg::*;
#(
    parameter int unsigned NUM_REGS = 4,
    parameter int unsigned REG_W    = 8,
    localparam int unsigned TOTAL     = NUM_REGS * REG_W,
    localparam int unsigned CTRL_ADDR = 2 * NUM_REGS,
    localparam int unsigned ADDR_W    = $clog2(CTRL_ADDR + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_rd,
    input  logic              reg_wr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic [TOTAL-1:0]  evt_in,
    output logic              irq
);

    typedef struct packed {
        logic [NUM_REGS-1:0][REG_W-1:0] mask;
        clr_mode_e                      mode;
        logic [REG_W-1:0]               rdata;
    } cfg_state_t;

    cfg_state_t cfg_d, cfg_q;

    logic                rd_pulse, wr_pulse;
    logic [NUM_REGS-1:0] rd_hit, wr_hit;
    logic [TOTAL-1:0]    stat_flat;
    logic [TOTAL-1:0]    mask_flat;

    stsb_strobe_edge u_edge (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_i       (reg_rd),
        .wr_i       (reg_wr),
        .rd_pulse_o (rd_pulse),
        .wr_pulse_o (wr_pulse)
    );

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_flag
        assign rd_hit[g] = rd_pulse && (reg_addr == ADDR_W'(g));
        assign wr_hit[g] = wr_pulse && (reg_addr == ADDR_W'(g));

        stsb_sticky_reg #(.W(REG_W)) u_reg (
            .clk      (clk),
            .rst_n    (rst_n),
            .mode_i   (cfg_q.mode),
            .rd_hit_i (rd_hit[g]),
            .wr_hit_i (wr_hit[g]),
            .wdata_i  (reg_wdata),
            .evt_i    (evt_in[g*REG_W +: REG_W]),
            .stat_o   (stat_flat[g*REG_W +: REG_W])
        );
    end

    assign mask_flat = cfg_q.mask;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_pulse) begin
            for (int k = 0; k < NUM_REGS; k++) begin
                if (reg_addr == ADDR_W'(NUM_REGS + k)) cfg_d.mask[k] = reg_wdata;
            end
            if (reg_addr == ADDR_W'(CTRL_ADDR)) cfg_d.mode = clr_mode_e'(reg_wdata[MODE_BIT]);
        end
        if (rd_pulse) begin
            cfg_d.rdata = '0;
            for (int k = 0; k < NUM_REGS; k++) begin
                if (reg_addr == ADDR_W'(k))            cfg_d.rdata = stat_flat[k*REG_W +: REG_W];
                if (reg_addr == ADDR_W'(NUM_REGS + k)) cfg_d.rdata = cfg_q.mask[k];
            end
            if (reg_addr == ADDR_W'(CTRL_ADDR)) begin
                cfg_d.rdata           = '0;
                cfg_d.rdata[MODE_BIT] = cfg_q.mode;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q      <= '0;
            cfg_q.mode <= CLR_BY_WRITE;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign reg_rdata = cfg_q.rdata;

    stsb_irq_or #(.N(TOTAL)) u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .stat_i (stat_flat),
        .mask_i (mask_flat),
        .irq_o  (irq)
    );

    // R9
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_pulse |=> $stable(reg_rdata));

    // R10
    mask_read_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_pulse && !wr_pulse && reg_addr >= ADDR_W'(NUM_REGS)) |=> $stable(mask_flat));

    // R5
    one_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rd_hit) && $onehot0(wr_hit));

endmodule

// File: tb/sim_sticky_status_bank.sv
module sim_sticky_status_bank;

    localparam int NR = 4;
    localparam int RW = 8;
    localparam int AW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] reg_addr = '0;
    logic          reg_rd = 1'b0;
    logic          reg_wr = 1'b0;
    logic [RW-1:0] reg_wdata = '0;
    logic [RW-1:0] reg_rdata;
    logic [NR*RW-1:0] evt_in = '0;
    logic          irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    sticky_status_bank #(.NUM_REGS(NR), .REG_W(RW)) u0 (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_rd(reg_rd),
        .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .evt_in(evt_in), .irq(irq)
    );

    task automatic check(input string tag, input logic [RW-1:0] got, input logic [RW-1:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h exp %h", tag, got, exp);
        end
    endtask

    task automatic do_read(input int a, output logic [RW-1:0] d);
        @(negedge clk); reg_addr = AW'(a); reg_rd = 1'b1;
        @(negedge clk); d = reg_rdata; reg_rd = 1'b0;
    endtask

    task automatic do_write(input int a, input logic [RW-1:0] v);
        @(negedge clk); reg_addr = AW'(a); reg_wdata = v; reg_wr = 1'b1;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic pulse_evt(input int r, input logic [RW-1:0] bits);
        @(negedge clk); evt_in[r*RW +: RW] = bits;
        @(negedge clk); evt_in = '0;
    endtask

    task automatic t_reset();
        logic [RW-1:0] d;
        check("R1 irq after reset", {7'b0, irq}, 8'h00);
        for (int a = 0; a <= 2*NR; a++) begin
            do_read(a, d);
            check("R1 reset value", d, 8'h00);
        end
    endtask

    task automatic t_set();
        logic [RW-1:0] d;
        pulse_evt(0, 8'h05);
        do_read(0, d); check("R2 event sets", d, 8'h05);
        do_read(0, d); check("R2 read keeps in write-clear", d, 8'h05);
        check("R9 rdata held", reg_rdata, 8'h05);
    endtask

    task automatic t_w1c();
        logic [RW-1:0] d;
        do_write(0, 8'h01); do_read(0, d); check("R3 clear one bit", d, 8'h04);
        do_write(0, 8'h00); do_read(0, d); check("R3 zero write keeps", d, 8'h04);
        do_write(0, 8'h04); do_read(0, d); check("R3 last bit cleared", d, 8'h00);
        pulse_evt(1, 8'hF0);
        do_write(1, 8'h30); do_read(1, d); check("R3 task A clears own", d, 8'hC0);
        do_write(1, 8'hC0); do_read(1, d); check("R3 task B clears own", d, 8'h00);
    endtask

    task automatic t_cor();
        logic [RW-1:0] d;
        do_write(2*NR, 8'h01); do_read(2*NR, d); check("R10 control readback", d, 8'h01);
        pulse_evt(2, 8'h81);
        do_read(2, d); check("R4 read returns pre-clear", d, 8'h81);
        do_read(2, d); check("R4 read cleared", d, 8'h00);
        pulse_evt(2, 8'h3C);
        do_write(2, 8'hFF); do_read(2, d); check("R6 write ignored", d, 8'h3C);
        do_read(2, d); check("R4 cleared after read", d, 8'h00);
    endtask

    task automatic t_held_read();
        logic [RW-1:0] d;
        pulse_evt(3, 8'h0F);
        @(negedge clk); reg_addr = AW'(3); reg_rd = 1'b1;
        @(negedge clk); check("R5 held read first data", reg_rdata, 8'h0F);
        evt_in[3*RW + 4] = 1'b1;
        @(negedge clk); evt_in = '0;
        repeat (3) @(negedge clk);
        reg_rd = 1'b0;
        do_read(3, d); check("R5 event during held strobe kept", d, 8'h10);
        do_read(3, d); check("R4 cleared", d, 8'h00);
    endtask

    task automatic t_collide_cor();
        logic [RW-1:0] d;
        pulse_evt(0, 8'h01);
        @(negedge clk); reg_addr = AW'(0); reg_rd = 1'b1; evt_in[1] = 1'b1;
        @(negedge clk); d = reg_rdata; reg_rd = 1'b0; evt_in = '0;
        check("R7 colliding read data", d, 8'h01);
        do_read(0, d); check("R7 event survives read clear", d, 8'h02);
        do_read(0, d); check("R4 cleared", d, 8'h00);
    endtask

    task automatic t_collide_w1c();
        logic [RW-1:0] d;
        do_write(2*NR, 8'h00); do_read(2*NR, d); check("R10 control back to write-clear", d, 8'h00);
        pulse_evt(1, 8'h01);
        @(negedge clk); reg_addr = AW'(1); reg_wdata = 8'h01; reg_wr = 1'b1; evt_in[RW] = 1'b1;
        @(negedge clk); reg_wr = 1'b0; evt_in = '0;
        do_read(1, d); check("R7 event survives write clear", d, 8'h01);
        do_write(1, 8'h01); do_read(1, d); check("R3 cleared", d, 8'h00);
    endtask

    task automatic t_irq();
        logic [RW-1:0] d;
        do_write(NR + 1, 8'h02); do_read(NR + 1, d); check("R10 mask readback", d, 8'h02);
        pulse_evt(1, 8'h01);
        @(negedge clk); check("R8 unmasked bit no irq", {7'b0, irq}, 8'h00);
        @(negedge clk); evt_in[RW + 1] = 1'b1;
        @(negedge clk); evt_in = '0;
        check("R8 irq lags one clock", {7'b0, irq}, 8'h00);
        @(negedge clk); check("R8 irq raised", {7'b0, irq}, 8'h01);
        do_write(1, 8'h02);
        check("R8 irq before fall", {7'b0, irq}, 8'h01);
        @(negedge clk); check("R8 irq cleared", {7'b0, irq}, 8'h00);
        do_read(1, d); check("R3 unmasked bit kept", d, 8'h01);
        do_write(1, 8'h01);
        do_read(NR + 1, d); check("R10 mask unchanged by read", d, 8'h02);
    endtask

    task automatic t_unmapped();
        logic [RW-1:0] d;
        do_write(15, 8'hFF);
        do_read(15, d); check("R10 unmapped reads zero", d, 8'h00);
        do_read(2*NR, d); check("R10 control untouched", d, 8'h00);
        do_read(NR, d); check("R10 mask0 untouched", d, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_set();
        t_w1c();
        t_cor();
        t_held_read();
        t_collide_cor();
        t_collide_w1c();
        t_irq();
        t_unmapped();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog got timeout exp completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule